// File: doc/BRIEF.md
# Microsecond System Timer with Compare Channels

This peripheral keeps a 64-bit count of microseconds since reset. A prescaler divides the system clock down to a single-cycle tick, and each tick adds one to the counter. Bus masters read the counter through two 32-bit windows, one for each half. The bus cannot write the counter.

Four 32-bit compare channels watch the lower half of the counter. On the tick that makes the lower half equal to a channel's compare value, that channel's pending flag is set. A pending flag stays set until software writes a 1 to its position in the status word. The single interrupt line is raised while any flag is pending.

The register bus is a plain single-cycle port. An access is selected by `busEn`, and `busWrite` picks the direction. A write takes effect at the clock edge on which `busEn` is high. Read data is combinational from the address while `busEn` is high and `busWrite` is low. Every access is one full 32-bit word.

Top module: `systimer`

## Requirements
- R1: The counter starts at zero after reset and advances by exactly one every `TICK_DIV` system clock cycles.
- R2: The counter is 64 bits wide, and each tick adds one to the whole 64-bit value.
- R3: A read at byte offset 0x04 returns counter bits 31:0, and a read at offset 0x08 returns counter bits 63:32.
- R4: A write to offset 0x04 or 0x08 leaves the counter unchanged.
- R5: The compare register of channel n is at offset 0x0C + 4·n, for n = 0 to 3. It reads back the last value written to it and is zero after reset.
- R6: On the tick that makes counter bits 31:0 equal to compare channel n, status bit n is set.
- R7: The status word is at offset 0x00. Channel n uses bit n, and bits 31:4 read as zero. Writing the word clears every bit written as 1 and leaves every bit written as 0 unchanged. The status is zero after reset.
- R8: `irq` is high exactly while at least one status bit is set. It falls in the cycle after an acknowledge write clears the last pending bit.
- R9: Reads from offset 0x1C, or from any offset whose two low bits are not zero, return zero. Writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Access select |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 5 | Byte offset inside the 32-byte window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when no read is selected |
| irq | output | 1 | High while any status bit is pending |

## Verification
The register file is driven with a table of aligned writes followed by reads. The table covers distinct values in each compare channel, which separates the four register slots from one another. It includes writes to the counter offsets that must not stick, and accesses to the empty slot and to misaligned offsets. These accesses show whether the decoder ignores an address or aliases it onto a neighbouring register. The counting path is tried by reading the counter twice, a known multiple of the prescale period apart. This distinguishes a correct divide ratio from an off-by-one in the prescaler. Compare channels are tried singly and in pairs that match on the same tick. Partial and full acknowledge patterns then show that each status bit clears on its own and that the interrupt follows the last pending bit.

// File: rtl/systimer_pkg.sv
package systimer_pkg;
  localparam int NUM_CMP = 4;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 64;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_CNT_LO,
    RD_CNT_HI,
    RD_CMP
  } rdSel_e;

  typedef struct packed {
    logic               ackStatus;
    logic [NUM_CMP-1:0] cmpWr;
    rdSel_e             rdSel;
    logic [1:0]         cmpIdx;
  } busCtl_t;
endpackage

// File: rtl/systimer_ctrl.sv
module systimer_ctrl
  import systimer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busEn,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busCtl_t           ctl
);
  localparam int WORD_IDX_W = ADDR_W - 2;

  logic                  aligned;
  logic [WORD_IDX_W-1:0] wordIdx;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    ctl.ackStatus = 1'b0;
    ctl.cmpWr     = '0;
    ctl.rdSel     = RD_NONE;
    ctl.cmpIdx    = 2'(wordIdx - WORD_IDX_W'(3));
    if (busEn && aligned) begin
      if (busWrite) begin
        if (wordIdx == WORD_IDX_W'(0)) begin
          ctl.ackStatus = 1'b1;
        end else if (wordIdx >= WORD_IDX_W'(3) &&
                     wordIdx < WORD_IDX_W'(3 + NUM_CMP)) begin
          ctl.cmpWr[ctl.cmpIdx] = 1'b1;
        end
      end else begin
        if (wordIdx == WORD_IDX_W'(0)) begin
          ctl.rdSel = RD_STATUS;
        end else if (wordIdx == WORD_IDX_W'(1)) begin
          ctl.rdSel = RD_CNT_LO;
        end else if (wordIdx == WORD_IDX_W'(2)) begin
          ctl.rdSel = RD_CNT_HI;
        end else if (wordIdx < WORD_IDX_W'(3 + NUM_CMP)) begin
          ctl.rdSel = RD_CMP;
        end
      end
    end
  end
endmodule

// File: rtl/systimer_dp.sv
module systimer_dp
  import systimer_pkg::*;
#(
  parameter int TICK_DIV = 200
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  busCtl_t                   ctl,
  input  logic [WORD_W-1:0]         busWdata,
  output logic [WORD_W-1:0]         busRdata,
  output logic                      tick,
  output logic [CNT_W-1:0]          count,
  output logic [NUM_CMP-1:0]        status,
  output logic [NUM_CMP*WORD_W-1:0] cmpFlat
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [WORD_W-1:0]  cmpReg [NUM_CMP];
  logic [CNT_W-1:0]   nextCount;
  logic [NUM_CMP-1:0] hit;
  logic [NUM_CMP-1:0] ackMask;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (divCnt == DIV_W'(TICK_DIV - 1)) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      assign tick = (divCnt == DIV_W'(TICK_DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  assign nextCount = count + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (tick) begin
      count <= nextCount;
    end
  end

  genvar n;
  generate
    for (n = 0; n < NUM_CMP; n++) begin : g_cmp
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cmpReg[n] <= '0;
        end else if (ctl.cmpWr[n]) begin
          cmpReg[n] <= busWdata;
        end
      end
      assign hit[n] = tick && (nextCount[WORD_W-1:0] == cmpReg[n]);
      assign cmpFlat[n*WORD_W +: WORD_W] = cmpReg[n];
    end
  endgenerate

  assign ackMask = ctl.ackStatus ? busWdata[NUM_CMP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
    end else begin
      status <= (status & ~ackMask) | hit;
    end
  end

  always_comb begin
    case (ctl.rdSel)
      RD_STATUS: busRdata = WORD_W'(status);
      RD_CNT_LO: busRdata = count[WORD_W-1:0];
      RD_CNT_HI: busRdata = count[CNT_W-1:WORD_W];
      RD_CMP:    busRdata = cmpReg[ctl.cmpIdx];
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/systimer.sv
module systimer
  import systimer_pkg::*;
#(
  parameter int TICK_DIV = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busEn,
  input  logic        busWrite,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq
);
  busCtl_t                   ctl;
  logic                      tick;
  logic [CNT_W-1:0]          count;
  logic [NUM_CMP-1:0]        status;
  logic [NUM_CMP*WORD_W-1:0] cmpFlat;

  systimer_ctrl #(.ADDR_W(5)) u_ctrl (
    .busEn   (busEn),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .ctl     (ctl)
  );

  systimer_dp #(.TICK_DIV(TICK_DIV)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .tick    (tick),
    .count   (count),
    .status  (status),
    .cmpFlat (cmpFlat)
  );

  assign irq = |status;
endmodule

// File: rtl/systimer_checker.sv
module systimer_checker #(
  parameter int TICK_DIV = 200
) (
  input logic         clk,
  input logic         rstN,
  input logic         tick,
  input logic [63:0]  count,
  input logic [3:0]   status,
  input logic [127:0] cmpFlat,
  input logic         irq,
  input logic         busEn,
  input logic         busWrite,
  input logic [4:0]   busAddr,
  input logic [31:0]  busWdata,
  input logic [31:0]  busRdata
);
  logic ackWr, cmpWrAny, badAddr;
  assign ackWr    = busEn && busWrite && (busAddr == 5'h00);
  assign cmpWrAny = busEn && busWrite && (busAddr[1:0] == 2'b00) &&
                    (busAddr >= 5'h0C) && (busAddr <= 5'h18);
  assign badAddr  = (busAddr[1:0] != 2'b00) || (busAddr == 5'h1C);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (count == $past(count) + 64'd1));

  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count));

  generate
    if (TICK_DIV > 1) begin : g_gap
      p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

  p_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cmpWrAny |=> $stable(cmpFlat));

  p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ackWr |=> ((status & $past(status)) == $past(status)));

  p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackWr && !tick && ((busWdata[3:0] & status) == status)) |=> !irq);

  p_undecoded_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busWrite && badAddr) |-> (busRdata == 32'd0));
endmodule

bind systimer systimer_checker #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .count   (count),
  .status  (status),
  .cmpFlat (cmpFlat),
  .irq     (irq),
  .busEn   (busEn),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata)
);

// File: tb/systimer_test.sv
module systimer_test;
  localparam int TD = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  systimer #(.TICK_DIV(TD)) uut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'h0C, 32'hA5A5_0001, 32'h0, 4'd5},          // R5
    '{1'b1, 5'h10, 32'hFFFF_0002, 32'h0, 4'd5},          // R5
    '{1'b1, 5'h14, 32'hFFFF_0003, 32'h0, 4'd5},          // R5
    '{1'b1, 5'h18, 32'hFFFF_0004, 32'h0, 4'd5},          // R5
    '{1'b0, 5'h0C, 32'h0, 32'hA5A5_0001, 4'd5},          // R5
    '{1'b0, 5'h10, 32'h0, 32'hFFFF_0002, 4'd5},          // R5
    '{1'b0, 5'h14, 32'h0, 32'hFFFF_0003, 4'd5},          // R5
    '{1'b0, 5'h18, 32'h0, 32'hFFFF_0004, 4'd5},          // R5
    '{1'b1, 5'h08, 32'hDEAD_BEEF, 32'h0, 4'd4},          // R4
    '{1'b0, 5'h08, 32'h0, 32'h0, 4'd4},                  // R4 R3 high word
    '{1'b1, 5'h1C, 32'h1234_5678, 32'h0, 4'd9},          // R9
    '{1'b0, 5'h1C, 32'h0, 32'h0, 4'd9},                  // R9
    '{1'b0, 5'h0E, 32'h0, 32'h0, 4'd9},                  // R9 misaligned
    '{1'b1, 5'h0D, 32'h0, 32'h0, 4'd9},                  // R9 misaligned write
    '{1'b0, 5'h0C, 32'h0, 32'hA5A5_0001, 4'd9},          // R9 slot untouched
    '{1'b1, 5'h00, 32'hFFFF_FFFF, 32'h0, 4'd7},          // R7
    '{1'b0, 5'h00, 32'h0, 32'h0, 4'd7}                   // R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    busEn = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busEn = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    busEn = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    busEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, c0, c1;
    idle(3);
    rstN = 1'b1;
    // reset state
    busRd(5'h04, rd); check("R1 counter low after reset", rd, 32'h0);
    busRd(5'h08, rd); check("R3 counter high after reset", rd, 32'h0);
    busRd(5'h00, rd); check("R7 status after reset", rd, 32'h0);
    busRd(5'h14, rd); check("R5 compare after reset", rd, 32'h0);
    check("R8 irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        busWr(VEC[i].addr, VEC[i].data);
      end else begin
        busRd(VEC[i].addr, rd);
        check($sformatf("R%0d table entry %0d", VEC[i].req, i), rd, VEC[i].expv);
      end
    end

    // R1 R2: counter advances once per TD cycles
    busRd(5'h04, c0);
    idle(10 * TD - 1);
    busRd(5'h04, c1);
    check("R1 ten prescale periods", c1 - c0, 32'd10);
    busWr(5'h04, 32'h0);
    busRd(5'h04, rd);
    check("R4 low word not cleared by write", {31'b0, (rd >= c1)}, 32'h1);
    busRd(5'h08, rd); check("R2 high word still zero", rd, 32'h0);

    // R6: single channel match
    busRd(5'h04, c0);
    busWr(5'h14, c0 + 32'd3);
    idle(6 * TD);
    busRd(5'h00, rd); check("R6 channel 2 hit", rd, 32'h4);
    check("R8 irq with pending bit", {31'b0, irq}, 32'h1);
    busWr(5'h00, 32'h1);
    busRd(5'h00, rd); check("R7 zero bits keep value", rd, 32'h4);
    busWr(5'h00, 32'h4);
    busRd(5'h00, rd); check("R7 acknowledge clears", rd, 32'h0);
    check("R8 irq low after ack", {31'b0, irq}, 32'h0);

    // R6: two channels match on the same tick
    busRd(5'h04, c0);
    busWr(5'h0C, c0 + 32'd2);
    busWr(5'h18, c0 + 32'd2);
    idle(5 * TD);
    busRd(5'h00, rd); check("R6 channels 0 and 3 hit", rd, 32'h9);
    busWr(5'h00, 32'h8);
    busRd(5'h00, rd); check("R7 partial ack", rd, 32'h1);
    check("R8 irq held by remaining bit", {31'b0, irq}, 32'h1);
    busWr(5'h00, 32'h1);
    check("R8 irq low after last ack", {31'b0, irq}, 32'h0);

    // R6: past compare value does not fire
    idle(4 * TD);
    busRd(5'h00, rd); check("R6 no hit once passed", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule